// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models the command side of a byte-wide parallel NOR flash with a 17-bit address. It watches host bus cycles built from chip-enable, write-enable and output-enable, all active low and sampled on the block clock. From the write cycles it recognises two-cycle unlock prefixes and the commands that follow them: identification (autoselect), byte program and reset. It then decides what a read cycle returns. The choices are array contents, identification codes, a sector protect flag, or the status of a program operation that is still running.

The storage is a small behavioural memory. Only the low `MEM_AW` address bits index it; the upper bits are ignored. A down-counter stands in for the embedded program algorithm. A program operation can only clear bits. If the written data tries to raise a stored 0 to 1, the operation ends in an error state. That state is reported through a status bit and is cleared only by a reset command.

Top module: `flash_cmd_top`

## Requirements
- R1: After rst_n is released the block is in array-read mode. Every array byte reads FFh, a read needs no prior command, and dq_oe is 1 exactly while ce_n=0, oe_n=0 and we_n=1.
- R2: A write cycle takes its address when ce_n and we_n first both become low, and its data when either of them goes high again. Address or data changes after those points have no effect.
- R3: The unlock prefix is AAh written at address 555h followed by 55h at 2AAh, with only address bits [10:0] compared. A write whose address or data does not match the expected step returns the block to array-read mode.
- R4: Unlock followed by 90h at 555h enters autoselect mode. Reads there decode address bits [7:0] at any upper address: 00h gives MFR_CODE (37h), 01h gives DEV_CODE (4Ch), 03h gives CONT_CODE (7Fh), and any other value except 02h gives 00h.
- R5: In autoselect mode a read with address bits [7:0]=02h returns 01h when the sector selected by address bits [16:14] has its bit set in SECT_PROT, and 00h otherwise. The default SECT_PROT is 04h, so only sector 2 is protected.
- R6: Autoselect mode is left only by a write of F0h, at any address, which returns the block to array-read mode. Other writes leave it in autoselect mode.
- R7: Unlock followed by A0h at 555h, then one write of address and data, stores the old byte AND the new data at that address. Array index is address bits [MEM_AW-1:0].
- R8: For PROG_CYCLES clock cycles after the program write, every read returns status. Bit 7 is the complement of bit 7 of the programmed data, bit 6 inverts on every read, bit 5 is 0, and bits 4..0 are 0. The block then returns to array-read mode.
- R9: Writes made while a program operation runs, including F0h, are ignored.
- R10: An F0h write during the unlock steps, before a command byte is accepted, returns the block to array-read mode.
- R11: If the program data has a 1 where the stored byte has a 0, the stored bit stays 0. After the busy period, reads return status with bit 5 set until an F0h write returns the block to array-read mode. Other writes are ignored in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 17 | Host address |
| din | input | 8 | Host write data |
| dq_out | output | 8 | Read data, zero when not driving |
| dq_oe | output | 1 | High while the block drives dq_out |

## Verification
The hardest state to reach from the ports is a write that lands while the program counter is still running. The bench has to fit several status reads and an F0h write into the busy window, counting each bus cycle, and then show that the reads still return status. The same applies to the error state: it appears only after a program whose data raises a cleared bit. It is reached on purpose by programming FFh over a byte that already holds zeros. It is also reached by random programs whose data is sometimes masked by the bench's copy of the array and sometimes left raw. The address is scrambled after the strobe falls and the data after it rises, and the order of the two enables is chosen at random, so every write also checks the capture points.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_ARRAY = 3'd0,
    M_UNL1  = 3'd1,
    M_UNL2  = 3'd2,
    M_AUTO  = 3'd3,
    M_PSET  = 3'd4,
    M_BUSY  = 3'd5,
    M_ERR   = 3'd6
  } mode_e;

  localparam int          CMD_AW   = 11;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  OP_IDENT = 8'h90;
  localparam logic [7:0]  OP_PROG  = 8'hA0;
  localparam logic [7:0]  OP_RESET = 8'hF0;
  localparam logic [CMD_AW-1:0] LOC_A = 11'h555;
  localparam logic [CMD_AW-1:0] LOC_B = 11'h2AA;

  // Stored result of programming: bits can only go from 1 to 0.
  function automatic logic [7:0] merge_prog(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // True when the new data tries to raise a cleared bit.
  function automatic logic raises_bit(input logic [7:0] old_b, input logic [7:0] new_b);
    return |(new_b & ~old_b);
  endfunction

  function automatic logic [7:0] status_byte(input logic [7:0] pd, input logic tgl, input logic err);
    return {~pd[7], tgl, err, 5'b0};
  endfunction

  function automatic logic [7:0] ident_byte(input logic [7:0] lo, input logic prot,
                                            input logic [7:0] mfr, input logic [7:0] dev,
                                            input logic [7:0] cont);
    case (lo)
      8'h00:   return mfr;
      8'h01:   return dev;
      8'h02:   return {7'b0, prot};
      8'h03:   return cont;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_bus_edge.sv
module flash_bus_edge #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_done,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_start
);
  logic wr_low, wr_low_q, rd_low, rd_low_q;
  logic [7:0] din_q;

  assign wr_low = ~ce_n & ~we_n;
  assign rd_low = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_q <= 1'b0;
      rd_low_q <= 1'b0;
      din_q    <= '0;
      wr_addr  <= '0;
    end else begin
      wr_low_q <= wr_low;
      rd_low_q <= rd_low;
      din_q    <= din;
      if (wr_low && !wr_low_q) wr_addr <= addr;
    end
  end

  // Strobe released: data is the value held while it was still low.
  assign wr_done  = wr_low_q & ~wr_low;
  assign wr_data  = din_q;
  assign rd_start = rd_low & ~rd_low_q;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [7:0]        rdata,
  output logic [7:0]        wold
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign wold  = mem[waddr];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic [CMD_AW-1:0] wr_lo,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        old_byte,
  input  logic              rd_start,
  output mode_e             mode,
  output logic              prog_start,
  output logic              busy_done,
  output logic [7:0]        prog_data,
  output logic              tgl
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          perr;
  mode_e         nxt;
  logic          at_a, at_b;

  assign at_a = (wr_lo == LOC_A);
  assign at_b = (wr_lo == LOC_B);

  always_comb begin
    case (mode)
      M_ARRAY: nxt = (at_a && wr_data == KEY_A) ? M_UNL1 : M_ARRAY;
      M_UNL1:  nxt = (at_b && wr_data == KEY_B) ? M_UNL2 : M_ARRAY;
      M_UNL2:  nxt = (at_a && wr_data == OP_IDENT) ? M_AUTO :
                     (at_a && wr_data == OP_PROG)  ? M_PSET : M_ARRAY;
      M_AUTO:  nxt = (wr_data == OP_RESET) ? M_ARRAY : M_AUTO;
      M_PSET:  nxt = M_BUSY;
      M_ERR:   nxt = (wr_data == OP_RESET) ? M_ARRAY : M_ERR;
      default: nxt = M_ARRAY;
    endcase
  end

  assign prog_start = wr_done && (mode == M_PSET);
  assign busy_done  = (mode == M_BUSY) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_ARRAY;
      cnt       <= '0;
      perr      <= 1'b0;
      prog_data <= '0;
      tgl       <= 1'b0;
    end else begin
      if (rd_start) tgl <= ~tgl;
      if (mode == M_BUSY) begin
        if (busy_done) mode <= perr ? M_ERR : M_ARRAY;
        else           cnt  <= cnt - 1'b1;
      end else if (wr_done) begin
        mode <= nxt;
        if (prog_start) begin
          cnt       <= CNT_LOAD;
          prog_data <= wr_data;
          perr      <= raises_bit(old_byte, wr_data);
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int          AW          = 17,
  parameter int          MEM_AW      = 8,
  parameter int          N_SECT      = 8,
  parameter int          PROG_CYCLES = 24,
  parameter logic [7:0]  MFR_CODE    = 8'h37,
  parameter logic [7:0]  DEV_CODE    = 8'h4C,
  parameter logic [7:0]  CONT_CODE   = 8'h7F,
  parameter logic [N_SECT-1:0] SECT_PROT = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  localparam int SW = $clog2(N_SECT);

  logic          wr_done, rd_start, prog_start, busy_done, tgl;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data, arr_q, old_byte, prog_data, rdata;
  mode_e         mode;
  logic          sect_prot;

  flash_bus_edge #(.AW(AW)) i_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .wr_done(wr_done), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_start(rd_start)
  );

  flash_array #(.MEM_AW(MEM_AW)) i_array (
    .clk(clk), .rst_n(rst_n), .we(prog_start),
    .waddr(wr_addr[MEM_AW-1:0]), .wdata(merge_prog(old_byte, wr_data)),
    .raddr(addr[MEM_AW-1:0]), .rdata(arr_q), .wold(old_byte)
  );

  flash_cmd_fsm #(.PROG_CYCLES(PROG_CYCLES)) i_fsm (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_lo(wr_addr[CMD_AW-1:0]),
    .wr_data(wr_data), .old_byte(old_byte), .rd_start(rd_start),
    .mode(mode), .prog_start(prog_start), .busy_done(busy_done),
    .prog_data(prog_data), .tgl(tgl)
  );

  assign sect_prot = SECT_PROT[addr[AW-1 -: SW]];

  always_comb begin
    case (mode)
      M_AUTO:  rdata = ident_byte(addr[7:0], sect_prot, MFR_CODE, DEV_CODE, CONT_CODE);
      M_BUSY:  rdata = status_byte(prog_data, tgl, 1'b0);
      M_ERR:   rdata = status_byte(prog_data, tgl, 1'b1);
      default: rdata = arr_q;
    endcase
  end

  assign dq_oe  = ~ce_n & ~oe_n & we_n;
  assign dq_out = dq_oe ? rdata : 8'h00;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input mode_e             mode,
  input logic              wr_done,
  input logic [7:0]        wr_data,
  input logic [CMD_AW-1:0] wr_lo,
  input logic              busy_done,
  input logic              prog_start
);
  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BUSY && !busy_done) |=> (mode == M_BUSY));

  assert_busy_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> (mode == M_ARRAY || mode == M_ERR));

  assert_auto_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_AUTO && !(wr_done && wr_data == OP_RESET)) |=> (mode == M_AUTO));

  assert_auto_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_AUTO && wr_done && wr_data == OP_RESET) |=> (mode == M_ARRAY));

  assert_bad_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UNL1 && wr_done && !(wr_data == KEY_B && wr_lo == LOC_B)) |=> (mode == M_ARRAY));

  assert_reset_in_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_UNL1 || mode == M_UNL2) && wr_done && wr_data == OP_RESET) |=> (mode == M_ARRAY));

  assert_prog_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> (mode == M_BUSY));

  assert_err_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERR && wr_done && wr_data == OP_RESET) |=> (mode == M_ARRAY));
endmodule

bind flash_cmd_top flash_cmd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .wr_done(wr_done), .wr_data(wr_data),
  .wr_lo(wr_addr[10:0]), .busy_done(busy_done), .prog_start(prog_start)
);

// File: tb/test_flash_cmd_top.sv
module test_flash_cmd_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCYC = 24;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0, dq_out;
  logic        dq_oe;
  int checks = 0, fails = 0;
  logic [7:0] shadow [256];

  flash_cmd_top i_flash_cmd_top (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_status(input logic [7:0] d, input logic err);
    logic [7:0] s;
    s = 8'h00;
    s[7] = ~d[7];
    s[5] = err;
    return s;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    logic we_first;
    we_first = $urandom % 2;
    @(negedge clk); addr = a; din = d;
    if (we_first) we_n = 1'b0; else ce_n = 1'b0;
    @(negedge clk);
    if (we_first) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk); addr = 17'($urandom);
    @(negedge clk);
    if (we_first) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk); din = 8'($urandom); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] q);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); q = dq_out;
    chk("R1 dq_oe during read", {7'b0, dq_oe}, 8'h01);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic unlock();
    wr(17'h00555, 8'hAA);
    wr(17'h002AA, 8'h55);
  endtask

  task automatic settle();
    repeat (PCYC + 6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q, s1, s2;
    logic [16:0] a;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dq_oe idle", {7'b0, dq_oe}, 8'h00);
    rd(17'h00005, q); chk("R1 erased array", q, 8'hFF);

    // R7 R8 R9 program with status reads and ignored writes while busy
    unlock(); wr(17'h00555, 8'hA0); wr(17'h00010, 8'h5A);
    rd(17'h00010, s1); chk("R8 status bits", s1 & 8'hBF, exp_status(8'h5A, 1'b0));
    rd(17'h00033, s2); chk("R8 toggle bit", (s1 ^ s2) & 8'h40, 8'h40);
    wr(17'h00000, 8'hF0);
    rd(17'h00010, q); chk("R9 reset ignored while busy", q & 8'hBF, exp_status(8'h5A, 1'b0));
    settle();
    shadow[8'h10] = 8'h5A;
    rd(17'h1F010, q); chk("R7 R2 programmed byte", q, 8'h5A);

    // R3 bad unlock data, bad unlock address
    wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h54); wr(17'h00555, 8'h90);
    rd(17'h00001, q); chk("R3 wrong data stays in array", q, 8'hFF);
    wr(17'h00555, 8'hAA); wr(17'h002AB, 8'h55); wr(17'h00555, 8'h90);
    rd(17'h00010, q); chk("R3 wrong address stays in array", q, 8'h5A);

    // R4 R5 R6 autoselect
    unlock(); wr(17'h00555, 8'h90);
    rd(17'h12300, q); chk("R4 manufacturer", q, 8'h37);
    rd(17'h00001, q); chk("R4 device", q, 8'h4C);
    rd(17'h04503, q); chk("R4 continuation", q, 8'h7F);
    rd(17'h00005, q); chk("R4 other offset", q, 8'h00);
    rd(17'h08002, q); chk("R5 sector 2 protected", q, 8'h01);
    rd(17'h00002, q); chk("R5 sector 0 unprotected", q, 8'h00);
    rd(17'h1C002, q); chk("R5 sector 7 unprotected", q, 8'h00);
    wr(17'h00555, 8'hAA); wr(17'h002AA, 8'h55);
    rd(17'h00000, q); chk("R6 other writes ignored", q, 8'h37);
    wr(17'h13579, 8'hF0);
    rd(17'h00010, q); chk("R6 reset leaves autoselect", q, 8'h5A);

    // R10 reset between unlock steps
    wr(17'h00555, 8'hAA); wr(17'h00123, 8'hF0);
    wr(17'h002AA, 8'h55); wr(17'h00555, 8'hA0); wr(17'h00020, 8'h00);
    settle();
    rd(17'h00020, q); chk("R10 reset after first unlock", q, 8'hFF);
    unlock(); wr(17'h00000, 8'hF0); wr(17'h00555, 8'h90);
    rd(17'h00000, q); chk("R10 reset after second unlock", q, 8'hFF);

    // R11 raise a cleared bit
    unlock(); wr(17'h00555, 8'hA0); wr(17'h00010, 8'hFF);
    settle();
    rd(17'h00010, s1); chk("R11 error status", s1 & 8'hBF, exp_status(8'hFF, 1'b1));
    wr(17'h00555, 8'hAA);
    rd(17'h00010, s2); chk("R11 error holds", s2 & 8'hBF, exp_status(8'hFF, 1'b1));
    chk("R8 toggle in error", (s1 ^ s2) & 8'h40, 8'h40);
    wr(17'h00000, 8'hF0);
    rd(17'h00010, q); chk("R11 cleared bits stay", q, 8'h5A);

    // Random programs and reads (R7, R11)
    for (int n = 0; n < 40; n++) begin
      a = 17'($urandom);
      d = 8'($urandom);
      if ($urandom % 3 != 0) d = d & shadow[a[7:0]];
      unlock(); wr(17'h00555, 8'hA0); wr(a, d);
      settle();
      if (|(d & ~shadow[a[7:0]])) begin
        rd(a, q); chk("R11 random error status", q & 8'hBF, exp_status(d, 1'b1));
        wr(17'($urandom), 8'hF0);
      end
      shadow[a[7:0]] = shadow[a[7:0]] & d;
      rd(a, q); chk("R7 random readback", q, shadow[a[7:0]]);
      a = 17'($urandom);
      rd(a, q); chk("R7 random array read", q, shadow[a[7:0]]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule